// File: doc/BRIEF.md
# Accumulator Fetch-Decode-Execute Processor

This block is a small multi-cycle processor built around one accumulator. Its sequencer moves every instruction through a fixed set of register transfers. The program counter goes to the address register. Memory returns the word into the data register. The word moves to the instruction register, and only then is it decoded and executed. Programs and data share one single-port memory. The block drives an address, a write-data word and separate read and write strobes. Read data comes back one cycle after the read strobe.

An instruction word is 12 bits wide. The upper 4 bits select the operation and the lower 8 bits name a memory location, so there are 256 locations. The accumulator and every memory word are also 12 bits wide. The processor starts at address 0 when reset is released. It runs until it meets a halt instruction, and then it raises `halted` and waits for the next reset.

Top module: `acc_cpu`

## Requirements
- R1: A synchronous reset clears the program counter, the accumulator and the internal registers. While reset is held, `mem_rd`, `mem_wr` and `halted` are low. A store as the first instruction after reset writes 0.
- R2: Each instruction starts with one cycle that has no strobe. In its second cycle it reads the program counter address (cycle 1, counting the first cycle of the instruction as cycle 0). The program counter advances during that read, so consecutive instructions are fetched from consecutive addresses.
- R3: The opcode is bits [11:8] and the operand address is bits [7:0]. The opcode values are: 0 halt, 1 load, 2 store, 3 add, 4 subtract, 5 AND, 6 OR, 7 XOR, 8 NOT, 9 shift left, A shift right, B jump. An instruction that reads an operand issues that read at the operand address in cycle 5 and takes 8 cycles in total.
- R4: Load, add, subtract, AND, OR and XOR combine the accumulator with the operand word and write the result to the accumulator. The arithmetic is modulo 2^12.
- R5: NOT, shift left and shift right act on the accumulator alone and take 6 cycles with no data access. The shifts fill the vacated bit with 0.
- R6: A store takes 7 cycles. It asserts `mem_wr` for exactly one cycle (cycle 6) at the operand address, with the accumulator as data, and it leaves the accumulator unchanged.
- R7: A jump takes 5 cycles, and the next fetch reads the operand address.
- R8: Opcodes C to F take 5 cycles, make no memory access and leave the accumulator unchanged.
- R9: A halt raises `halted` in cycle 5. `halted` stays high with no memory strobe until reset, and reset clears it.
- R10: The program counter wraps from 0xFF to 0x00.
- R11: `mem_rd` and `mem_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 8 | Memory address (driven from the address register) |
| mem_rdata | input | 12 | Read data, valid one cycle after `mem_rd` |
| mem_wdata | output | 12 | Write data (driven from the data register) |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| halted | output | 1 | High after a halt instruction until reset |

## Verification
The assertions assume a memory that returns the addressed word exactly one cycle after `mem_rd` and never stalls. They also assume that reset is applied before the first edge that matters. The bench models the memory as a registered array that answers every read on the next edge. It loads programs only while reset is held, so the processor never sees a changing memory or a late reply. Every program uses only defined words or the reserved no-op codes, and each program ends in a halt or is stopped by a reset. This keeps the sequencer on the paths the properties describe.

// File: rtl/acc_cpu.sv
module acc_cpu #(
  parameter int AW = 8,
  parameter int OW = 4,
  localparam int WW = OW + AW
) (
  input  logic          clk,
  input  logic          rst,
  output logic [AW-1:0] mem_addr,
  input  logic [WW-1:0] mem_rdata,
  output logic [WW-1:0] mem_wdata,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic          halted
);

  localparam logic [OW-1:0] OP_HALT  = OW'(0);
  localparam logic [OW-1:0] OP_LOAD  = OW'(1);
  localparam logic [OW-1:0] OP_STORE = OW'(2);
  localparam logic [OW-1:0] OP_ADD   = OW'(3);
  localparam logic [OW-1:0] OP_SUB   = OW'(4);
  localparam logic [OW-1:0] OP_AND   = OW'(5);
  localparam logic [OW-1:0] OP_OR    = OW'(6);
  localparam logic [OW-1:0] OP_XOR   = OW'(7);
  localparam logic [OW-1:0] OP_NOT   = OW'(8);
  localparam logic [OW-1:0] OP_SHL   = OW'(9);
  localparam logic [OW-1:0] OP_SHR   = OW'(10);
  localparam logic [OW-1:0] OP_JMP   = OW'(11);

  typedef enum logic [3:0] {
    S_F_ADR, S_F_RD, S_F_CAP, S_F_IR, S_DEC,
    S_X_RD, S_X_CAP, S_X_ALU, S_ST_LD, S_ST_WR, S_HALT
  } state_t;

  state_t        state;
  logic [AW-1:0] pc, mar;
  logic [WW-1:0] mdr, cir, acc, alu_y;

  wire [OW-1:0] opc  = cir[WW-1:AW];
  wire [AW-1:0] opnd = cir[AW-1:0];

  always_comb begin
    case (opc)
      OP_LOAD: alu_y = mdr;
      OP_ADD:  alu_y = acc + mdr;
      OP_SUB:  alu_y = acc - mdr;
      OP_AND:  alu_y = acc & mdr;
      OP_OR:   alu_y = acc | mdr;
      OP_XOR:  alu_y = acc ^ mdr;
      OP_NOT:  alu_y = ~acc;
      OP_SHL:  alu_y = {acc[WW-2:0], 1'b0};
      OP_SHR:  alu_y = {1'b0, acc[WW-1:1]};
      default: alu_y = acc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_F_ADR;
      pc    <= '0;
      mar   <= '0;
      mdr   <= '0;
      cir   <= '0;
      acc   <= '0;
    end else begin
      case (state)
        S_F_ADR: begin mar <= pc; state <= S_F_RD; end
        S_F_RD:  begin pc <= pc + AW'(1); state <= S_F_CAP; end
        S_F_CAP: begin mdr <= mem_rdata; state <= S_F_IR; end
        S_F_IR:  begin cir <= mdr; state <= S_DEC; end
        S_DEC: begin
          mar <= opnd;
          case (opc)
            OP_HALT:  state <= S_HALT;
            OP_STORE: state <= S_ST_LD;
            OP_JMP:   begin pc <= opnd; state <= S_F_ADR; end
            OP_NOT, OP_SHL, OP_SHR: state <= S_X_ALU;
            OP_LOAD, OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR: state <= S_X_RD;
            default:  state <= S_F_ADR;
          endcase
        end
        S_X_RD:  state <= S_X_CAP;
        S_X_CAP: begin mdr <= mem_rdata; state <= S_X_ALU; end
        S_X_ALU: begin acc <= alu_y; state <= S_F_ADR; end
        S_ST_LD: begin mdr <= acc; state <= S_ST_WR; end
        S_ST_WR: state <= S_F_ADR;
        default: state <= S_HALT;
      endcase
    end
  end

  assign mem_addr  = mar;
  assign mem_wdata = mdr;
  assign mem_rd    = (state == S_F_RD) || (state == S_X_RD);
  assign mem_wr    = (state == S_ST_WR);
  assign halted    = (state == S_HALT);

  a_r11_single_port: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));
  a_r6_write_one_cycle: assert property (@(posedge clk) disable iff (rst)
    mem_wr |=> !mem_wr);
  a_r9_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);
  a_r9_halt_quiet: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!mem_rd && !mem_wr));
  a_r2_pc_ahead: assert property (@(posedge clk) disable iff (rst)
    (state == S_F_CAP) |-> (pc == mar + AW'(1)));
  a_r3_operand_addr: assert property (@(posedge clk) disable iff (rst)
    (state == S_X_RD) |-> (mem_addr == opnd));

endmodule

// File: tb/tb_acc_cpu.sv
module tb_acc_cpu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  mem_addr;
  logic [11:0] mem_rdata, mem_wdata;
  logic        mem_rd, mem_wr, halted;

  always #2.5 clk = ~clk;

  acc_cpu dut (.clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
               .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr), .halted(halted));

  logic [11:0] mem [256];
  logic        ld_en = 1'b0;
  logic [7:0]  ld_a = '0;
  logic [11:0] ld_d = '0;

  always @(posedge clk) begin
    if (ld_en) mem[ld_a] <= ld_d;
    else if (mem_wr) mem[mem_addr] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr];
  end

  int checks = 0, fails = 0;
  int cyc = 0, t = 0, halt_exp = -10;
  bit track = 0;
  bit          q_wr[$];
  logic [7:0]  q_addr[$];
  logic [11:0] q_data[$];
  int          q_cyc[$];
  string       q_req[$];

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push(bit wr, logic [7:0] a, logic [11:0] d, int c, string r);
    q_wr.push_back(wr); q_addr.push_back(a); q_data.push_back(d);
    q_cyc.push_back(c); q_req.push_back(r);
  endtask

  task automatic i_mem(logic [7:0] pc, logic [7:0] op, string r);
    push(0, pc, 0, t + 1, "R2"); push(0, op, 0, t + 5, r); t += 8;
  endtask
  task automatic i_un(logic [7:0] pc);
    push(0, pc, 0, t + 1, "R5"); t += 6;
  endtask
  task automatic i_st(logic [7:0] pc, logic [7:0] op, logic [11:0] d, string r);
    push(0, pc, 0, t + 1, "R2"); push(1, op, d, t + 6, r); t += 7;
  endtask
  task automatic i_short(logic [7:0] pc, string r);
    push(0, pc, 0, t + 1, r); t += 5;
  endtask
  task automatic i_halt(logic [7:0] pc);
    push(0, pc, 0, t + 1, "R9"); halt_exp = t + 5;
  endtask

  // monitor: pops expected accesses and compares kind, address, data and cycle
  always @(negedge clk) begin
    if (rst) cyc = 0;
    else begin
      if (track && (mem_rd || mem_wr)) begin
        chk(!(mem_rd && mem_wr), "R11", "both strobes", {mem_rd, mem_wr}, 2);
        if (q_cyc.size() == 0)
          chk(0, halted ? "R9" : "R8", "unexpected access", {23'd0, mem_wr, mem_addr}, 0);
        else begin
          chk(mem_wr == q_wr[0] && mem_addr == q_addr[0] && cyc == q_cyc[0]
              && (!mem_wr || mem_wdata == q_data[0]), q_req[0], "access wr/addr/cycle",
              {mem_wr, mem_addr, (mem_wr ? mem_wdata : 12'h0)} * 1000 + cyc,
              {q_wr[0], q_addr[0], q_data[0]} * 1000 + q_cyc[0]);
          void'(q_wr.pop_front()); void'(q_addr.pop_front()); void'(q_data.pop_front());
          void'(q_cyc.pop_front()); void'(q_req.pop_front());
        end
      end
      if (track && halt_exp > 0 && (cyc == halt_exp - 1 || cyc == halt_exp))
        chk(halted == (cyc == halt_exp), "R9", "halted timing", halted, cyc == halt_exp);
      cyc++;
    end
  end

  task automatic poke(logic [7:0] a, logic [11:0] d);
    ld_en = 1; ld_a = a; ld_d = d;
    @(posedge clk); #1 ld_en = 0;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) poke(i[7:0], 12'h000);
  endtask

  task automatic enter_reset();
    @(posedge clk); #1 rst = 1; track = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(!mem_rd && !mem_wr && !halted, "R1", "outputs in reset", {mem_rd, mem_wr, halted}, 0);
  endtask

  task automatic leave_reset();
    t = 0; track = 1;
    @(posedge clk); #1 rst = 0;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    enter_reset();
    clear_mem();
    poke(8'h00, 12'h266); poke(8'h01, 12'h140); poke(8'h02, 12'h341); poke(8'h03, 12'h260);
    poke(8'h04, 12'h442); poke(8'h05, 12'h261); poke(8'h06, 12'h543); poke(8'h07, 12'h644);
    poke(8'h08, 12'h745); poke(8'h09, 12'h262); poke(8'h0A, 12'h800); poke(8'h0B, 12'h900);
    poke(8'h0C, 12'h263); poke(8'h0D, 12'hA00); poke(8'h0E, 12'hC77); poke(8'h0F, 12'h264);
    poke(8'h10, 12'hB20); poke(8'h20, 12'hA00); poke(8'h21, 12'h265); poke(8'h22, 12'h000);
    poke(8'h40, 12'h123); poke(8'h41, 12'h0FF); poke(8'h42, 12'h300); poke(8'h43, 12'h0F0);
    poke(8'h44, 12'h505); poke(8'h45, 12'hFFF);
    i_st(8'h00, 8'h66, 12'h000, "R1");
    i_mem(8'h01, 8'h40, "R3");
    i_mem(8'h02, 8'h41, "R3");
    i_st(8'h03, 8'h60, 12'h222, "R4");   // load + add
    i_mem(8'h04, 8'h42, "R4");
    i_st(8'h05, 8'h61, 12'hF22, "R6");   // sub after store kept ACC: wraps mod 2^12
    i_mem(8'h06, 8'h43, "R4");
    i_mem(8'h07, 8'h44, "R4");
    i_mem(8'h08, 8'h45, "R4");
    i_st(8'h09, 8'h62, 12'hADA, "R4");   // and, or, xor
    i_un(8'h0A);
    i_un(8'h0B);
    i_st(8'h0C, 8'h63, 12'hA4A, "R5");   // not then shift left
    i_un(8'h0D);
    i_short(8'h0E, "R8");
    i_st(8'h0F, 8'h64, 12'h525, "R8");   // shift right, no-op left ACC alone
    i_short(8'h10, "R7");
    i_un(8'h20);
    i_st(8'h21, 8'h65, 12'h292, "R7");   // jump target ran, shift right zero fill
    i_halt(8'h22);
    leave_reset();
    while (q_cyc.size() != 0 || cyc <= halt_exp + 30) @(negedge clk);
    chk(halted, "R9", "halted held", halted, 1);
    chk(q_cyc.size() == 0, "R3", "pending accesses", q_cyc.size(), 0);

    enter_reset();
    chk(!halted, "R9", "halt cleared by reset", halted, 0);
    halt_exp = -10;
    clear_mem();
    poke(8'h00, 12'hBFE); poke(8'hFE, 12'h150); poke(8'hFF, 12'h251); poke(8'h50, 12'h777);
    i_short(8'h00, "R7");
    i_mem(8'hFE, 8'h50, "R10");
    i_st(8'hFF, 8'h51, 12'h777, "R10");
    push(0, 8'h00, 0, t + 1, "R10");
    leave_reset();
    while (q_cyc.size() != 0) @(negedge clk);

    enter_reset();
    clear_mem();
    poke(8'h00, 12'h266); poke(8'h01, 12'h000);
    i_st(8'h00, 8'h66, 12'h000, "R1");   // ACC held 0x777 before this reset
    i_halt(8'h01);
    leave_reset();
    while (q_cyc.size() != 0 || cyc <= halt_exp + 5) @(negedge clk);
    chk(halted, "R9", "second halt", halted, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule